// File: doc/BRIEF.md
# Guarded Register Write Sequencer

This block sits between a host write port and a slow peripheral register file whose write path cannot be trusted on its own. Each accepted host write is expanded into a fixed burst of three downstream writes on consecutive clock cycles. The first two are conditioning writes of zero to the status register at offset 0, and the third is the real write. The block then holds the host off for a settle time before it takes the next request. The settle time is a number of microseconds converted to clocks through a clocks-per-microsecond parameter.

The block also holds a 32-bit bridge timing control register that belongs to the block itself. It holds a 10-bit access period field and a 5-bit read-delay field. A host write to the parameterised local offset loads the whole register in one cycle, and no downstream traffic results. A one-cycle init pulse performs a read-modify-write that drives both fields to all ones and leaves every other bit as it was. Reset applies the same rule to the reset value.

The sequence is controlled by five states. `ST_IDLE` is ready and waits. `ST_GUARD_A` and `ST_GUARD_B` issue the two zero writes. `ST_COMMIT` issues the real write. `ST_SETTLE` waits for the settle timer. The transitions are:
- `ST_IDLE` goes to `ST_GUARD_A` on a guarded accept.
- `ST_GUARD_A` goes to `ST_GUARD_B`, then to `ST_COMMIT`, then to `ST_SETTLE`, each unconditionally.
- `ST_SETTLE` goes to `ST_IDLE` when the timer expires.

Top module: `guarded_write_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `dn_wr` is 0. `tmg_reg` equals `TIMING_RST` with bits 9:0 and bits 30:26 forced to ones.
- R2: A request with an offset other than `TIMING_OFS` is accepted on a clock edge where `req_valid` and `req_ready` are both 1. On the three cycles that follow, `dn_wr` is 1, and it is 0 on the cycle after those.
- R3: During the first two of the three writes, `dn_addr` is 0 and `dn_data` is 0.
- R4: During the third write, `dn_addr` and `dn_data` carry the offset and data that were accepted. They do so even if the host inputs have changed since the accept.
- R5: `req_ready` is 0 from the first zero write until SETTLE_US*CLK_PER_US cycles after the real write, and it is 1 on the cycle after that.
- R6: While `req_ready` is 0, `req_valid` has no effect: no extra downstream write occurs, and the real write carries the originally accepted values.
- R7: An accepted write to offset `TIMING_OFS` loads all 32 bits of `req_data` into `tmg_reg` on the next cycle. It causes no downstream write, and `req_ready` stays 1.
- R8: A `tmg_init` pulse sets bits 9:0 and bits 30:26 of `tmg_reg` to ones on the next cycle. All other bits are preserved.
- R9: When a `TIMING_OFS` write and `tmg_init` occur in the same cycle, the bits outside the two fields take the host data, and both fields become all ones.
- R10: `tmg_period` always equals `tmg_reg[9:0]`, and `tmg_rdelay` always equals `tmg_reg[30:26]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host write request valid |
| req_ready | output | 1 | Block can accept a request |
| req_offset | input | AW | Host write offset |
| req_data | input | DW | Host write data |
| tmg_init | input | 1 | Pulse: set both timing fields to maximum, keeping other bits |
| dn_wr | output | 1 | Downstream write strobe |
| dn_addr | output | AW | Downstream write offset |
| dn_data | output | DW | Downstream write data |
| tmg_reg | output | 32 | Whole bridge timing control register |
| tmg_period | output | 10 | Access period field |
| tmg_rdelay | output | 5 | Read-delay field |

## Verification
The bench builds the block with a 4-bit offset, a local timing offset of 15, 2 clocks per microsecond and a 3-microsecond settle. The settle window is therefore 6 cycles, and each guarded transaction lasts 9 cycles. With these values every guarded offset from 0 to 14 can be swept. Half of the sweep keeps `req_valid` high with changed data while the block is busy. The remaining cases cover local loads, init pulses and the simultaneous load-with-init case, with values that set and clear every bit outside the fields.

// File: rtl/gws_pkg.sv
package gws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_GUARD_A = 3'd1,
        ST_GUARD_B = 3'd2,
        ST_COMMIT  = 3'd3,
        ST_SETTLE  = 3'd4
    } seq_state_e;

    localparam int unsigned TMG_W      = 32;
    localparam int unsigned PER_LSB    = 0;
    localparam int unsigned PER_W      = 10;
    localparam int unsigned RDL_LSB    = 26;
    localparam int unsigned RDL_W      = 5;

    localparam logic [TMG_W-1:0] PER_MASK   = ((TMG_W'(1) << PER_W) - TMG_W'(1)) << PER_LSB;
    localparam logic [TMG_W-1:0] RDL_MASK   = ((TMG_W'(1) << RDL_W) - TMG_W'(1)) << RDL_LSB;
    localparam logic [TMG_W-1:0] FIELD_MASK = PER_MASK | RDL_MASK;

endpackage

// File: rtl/gws_settle_timer.sv
module gws_settle_timer #(
    parameter int unsigned CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(CYCLES - 1);
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired = (cnt == '0);

    // R5
    load_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == CW'(CYCLES - 1)));

endmodule

// File: rtl/gws_seq_fsm.sv
module gws_seq_fsm
    import gws_pkg::*;
#(
    parameter int unsigned AW         = 8,
    parameter int unsigned DW         = 32,
    parameter int unsigned SETTLE_CYC = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] in_offset,
    input  logic [DW-1:0] in_data,
    output logic          idle,
    output logic          wr,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    seq_state_e    state, state_nx;
    logic [AW-1:0] hold_off;
    logic [DW-1:0] hold_dat;
    logic          tmr_load, tmr_run, tmr_done;

    gws_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (tmr_run),
        .expired (tmr_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_GUARD_A;
            ST_GUARD_A: state_nx = ST_GUARD_B;
            ST_GUARD_B: state_nx = ST_COMMIT;
            ST_COMMIT:  state_nx = ST_SETTLE;
            ST_SETTLE:  if (tmr_done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hold_off <= '0;
            hold_dat <= '0;
        end else begin
            state <= state_nx;
            if ((state == ST_IDLE) && start) begin
                hold_off <= in_offset;
                hold_dat <= in_data;
            end
        end
    end

    always_comb begin
        idle     = 1'b0;
        wr       = 1'b0;
        wr_addr  = '0;
        wr_data  = '0;
        tmr_load = 1'b0;
        tmr_run  = 1'b0;
        unique case (state)
            ST_IDLE:    idle = 1'b1;
            ST_GUARD_A: wr = 1'b1;
            ST_GUARD_B: wr = 1'b1;
            ST_COMMIT: begin
                wr       = 1'b1;
                wr_addr  = hold_off;
                wr_data  = hold_dat;
                tmr_load = 1'b1;
            end
            ST_SETTLE:  tmr_run = 1'b1;
            default:    idle = 1'b0;
        endcase
    end

    // R4
    commit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> ##2 (wr_addr == $past(in_offset, 3) && wr_data == $past(in_data, 3)));

endmodule

// File: rtl/gws_timing_reg.sv
module gws_timing_reg
    import gws_pkg::*;
#(
    parameter logic [TMG_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMG_W-1:0] load_val,
    input  logic             init,
    output logic [TMG_W-1:0] value
);
    localparam logic [TMG_W-1:0] RST_EFF = (RST_VAL & ~FIELD_MASK) | FIELD_MASK;

    logic [TMG_W-1:0] base, nxt;

    always_comb begin
        base = load ? load_val : value;
        nxt  = init ? ((base & ~FIELD_MASK) | FIELD_MASK) : base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) value <= RST_EFF;
        else        value <= nxt;
    end

    // R8
    init_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> ((value & FIELD_MASK) == FIELD_MASK));

    // R8
    keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init && !load) |=> ((value & ~FIELD_MASK) == $past(value & ~FIELD_MASK)));

    // R9
    load_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init && load) |=> ((value & ~FIELD_MASK) == $past(load_val & ~FIELD_MASK)));

endmodule

// File: rtl/guarded_write_seq.sv
module guarded_write_seq
    import gws_pkg::*;
#(
    parameter int unsigned      AW         = 8,
    parameter int unsigned      DW         = 32,
    parameter int unsigned      CLK_PER_US = 100,
    parameter int unsigned      SETTLE_US  = 5,
    parameter logic [AW-1:0]    TIMING_OFS = '1,
    parameter logic [31:0]      TIMING_RST = 32'h0000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_offset,
    input  logic [DW-1:0] req_data,
    input  logic          tmg_init,
    output logic          dn_wr,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_data,
    output logic [31:0]   tmg_reg,
    output logic [9:0]    tmg_period,
    output logic [4:0]    tmg_rdelay
);
    localparam int unsigned SETTLE_CYC = (CLK_PER_US * SETTLE_US > 0) ? CLK_PER_US * SETTLE_US : 1;

    logic accept, is_local, go_guard, loc_wr;

    assign accept   = req_valid && req_ready;
    assign is_local = (req_offset == TIMING_OFS);
    assign go_guard = accept && !is_local;
    assign loc_wr   = accept && is_local;

    gws_seq_fsm #(
        .AW         (AW),
        .DW         (DW),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (go_guard),
        .in_offset (req_offset),
        .in_data   (req_data),
        .idle      (req_ready),
        .wr        (dn_wr),
        .wr_addr   (dn_addr),
        .wr_data   (dn_data)
    );

    gws_timing_reg #(.RST_VAL(TIMING_RST)) u_tmg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (loc_wr),
        .load_val (req_data[TMG_W-1:0]),
        .init     (tmg_init),
        .value    (tmg_reg)
    );

    assign tmg_period = tmg_reg[PER_LSB +: PER_W];
    assign tmg_rdelay = tmg_reg[RDL_LSB +: RDL_W];

    // Checker support: cycles since the last downstream write, saturating.
    localparam int unsigned GW = $clog2(SETTLE_CYC + 1);
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n)                      gap <= GW'(SETTLE_CYC);
        else if (dn_wr)                  gap <= '0;
        else if (gap != GW'(SETTLE_CYC)) gap <= gap + GW'(1);
    end

    // R2
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_wr) |=> dn_wr ##1 dn_wr ##1 !dn_wr);

    // R3
    guard_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_wr) |-> (dn_addr == '0 && dn_data == '0) ##1 (dn_addr == '0 && dn_data == '0));

    // R5
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_wr |-> !req_ready);

    // R5
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (gap == GW'(SETTLE_CYC)));

    // R7
    local_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wr |=> (!dn_wr && req_ready));

endmodule

// File: tb/guarded_write_seq_test.sv
module guarded_write_seq_test;
    localparam int unsigned AW = 4;
    localparam int unsigned DW = 32;
    localparam int unsigned CPU = 2;
    localparam int unsigned SUS = 3;
    localparam int unsigned S = CPU * SUS;
    localparam logic [AW-1:0] LOC = 4'hF;
    localparam logic [31:0] RSTV = 32'hA5A5_A5A5;
    localparam logic [31:0] FM = 32'h7C00_03FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_offset = '0;
    logic [DW-1:0] req_data = '0;
    logic tmg_init = 1'b0;
    logic dn_wr;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_data;
    logic [31:0] tmg_reg;
    logic [9:0] tmg_period;
    logic [4:0] tmg_rdelay;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] model;

    always #5 clk = ~clk;

    guarded_write_seq #(
        .AW(AW), .DW(DW), .CLK_PER_US(CPU), .SETTLE_US(SUS),
        .TIMING_OFS(LOC), .TIMING_RST(RSTV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_data(req_data), .tmg_init(tmg_init),
        .dn_wr(dn_wr), .dn_addr(dn_addr), .dn_data(dn_data),
        .tmg_reg(tmg_reg), .tmg_period(tmg_period), .tmg_rdelay(tmg_rdelay)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_tmg(input string req);
        check(req, tmg_reg, model);
        check({req, " R10 period"}, 32'(tmg_period), 32'(model[9:0]));
        check({req, " R10 rdelay"}, 32'(tmg_rdelay), 32'(model[30:26]));
    endtask

    // Guarded transaction; starts and ends at a negedge with ready high.
    task automatic guarded(input logic [AW-1:0] off, input logic [31:0] dat, input bit hold);
        check("R5 ready before", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_offset = off; req_data = dat;
        @(negedge clk);
        if (hold) begin
            req_offset = off ^ 4'h5; req_data = ~dat;   // R6: ignored while busy
        end else begin
            req_valid = 1'b0;
        end
        for (int k = 0; k < 2; k++) begin
            check("R2 guard wr", 32'(dn_wr), 32'd1);
            check("R3 guard addr", 32'(dn_addr), 32'd0);
            check("R3 guard data", dn_data, 32'd0);
            check("R5 busy ready", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        check("R2 commit wr", 32'(dn_wr), 32'd1);
        check("R4 R6 commit addr", 32'(dn_addr), 32'(off));
        check("R4 R6 commit data", dn_data, dat);
        check("R5 commit ready", 32'(req_ready), 32'd0);
        @(negedge clk);
        for (int k = 0; k < int'(S); k++) begin
            check("R2 R6 settle no wr", 32'(dn_wr), 32'd0);
            check("R5 settle ready", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        check("R5 ready back", 32'(req_ready), 32'd1);
        check("R6 no extra wr", 32'(dn_wr), 32'd0);
        req_valid = 1'b0;
    endtask

    task automatic local_wr(input logic [31:0] dat, input bit with_init);
        req_valid = 1'b1; req_offset = LOC; req_data = dat; tmg_init = with_init;
        @(negedge clk);
        req_valid = 1'b0; tmg_init = 1'b0;
        model = with_init ? ((dat & ~FM) | FM) : dat;
        check(with_init ? "R9 load+init" : "R7 load", tmg_reg, model);
        check_tmg("R7 R9 fields");
        check("R7 no dn wr", 32'(dn_wr), 32'd0);
        check("R7 ready stays", 32'(req_ready), 32'd1);
    endtask

    task automatic do_init();
        tmg_init = 1'b1;
        @(negedge clk);
        tmg_init = 1'b0;
        model = (model & ~FM) | FM;
        check("R8 init", tmg_reg, model);
        check_tmg("R8 fields");
        check("R8 no dn wr", 32'(dn_wr), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h1234_5678;
        pats[3] = 32'h8000_0000; pats[4] = 32'h03FF_FC00; pats[5] = 32'hC3A5_0011;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model = (RSTV & ~FM) | FM;
        check("R1 ready", 32'(req_ready), 32'd1);
        check("R1 dn_wr", 32'(dn_wr), 32'd0);
        check_tmg("R1 tmg");
        for (int o = 0; o < 15; o++) begin
            guarded(AW'(o), (32'h1357_9BDF * (o + 1)) ^ {8'(o), 24'h5A5A5A}, o[0]);
        end
        for (int p = 0; p < 6; p++) begin
            local_wr(pats[p], 1'b0);
            do_init();
            local_wr(~pats[p], 1'b1);
        end
        guarded(4'h0, 32'hDEAD_BEEF, 1'b1);
        check_tmg("R7 tmg unaffected by guarded");
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule